// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the byte-wide register file that sits between a processor bus and the command engine of an SMBus host controller. The processor reaches it through a 5-bit address, 8-bit data interface with separate read and write strobes. The block holds the settings for the next transfer: control, command code, target address, two data bytes, auxiliary control and a notify address. It also holds two status registers that the engine sets and software clears. A 32-byte block buffer sits behind a single data-port address. An internal offset walks through the buffer, and a read of the control register returns that offset to zero.

Writing the control register with its start bit set produces a one-cycle start pulse toward the command engine. The start bit is not kept in the stored control value. The engine has its own side port. Through it the engine can set status bits, load the two data bytes and read or write any buffer entry. When the engine and the host update the same storage in the same cycle, the engine wins. Reads return data combinationally in the cycle the read strobe is high. Their side effects take place at the clock edge that ends that cycle.

Top module: `smb_host_regs`

## Requirements
- R1: After a synchronous active-high reset, every register, every buffer entry, the block offset and the start pulse are zero.
- R2: A host write to the host status register (address 0x00) clears each bit written as 1 and keeps each bit written as 0.
- R3: The secondary status register (address 0x10) follows the same write-one-to-clear rule as R2. The engine sets its bits through a separate set mask.
- R4: A host write to the block data port (address 0x07) stores the byte in the buffer entry at the current offset, and the offset then advances by one.
- R5: A host read of the block data port returns the buffer entry at the current offset, and the offset then advances by one.
- R6: A host read of the control register (address 0x02) returns the stored control value and resets the block offset to zero.
- R7: A control write with bit 6 set stores the value with bit 6 cleared. It also drives start_pulse high for exactly the one cycle that follows the write edge. A control write with bit 6 clear gives no pulse.
- R8: A host write to command (0x03), target address (0x04), data byte 0 (0x05), data byte 1 (0x06), auxiliary control (0x0D) or notify address (0x14) stores the byte unchanged, and a read at that address returns it.
- R9: Reads of any address not listed in R2 to R8 return zero. Writes to those addresses change no register and no buffer entry.
- R10: The block offset wraps from 31 back to 0, so the 33rd consecutive block write lands in entry 0.
- R11: In the same cycle, an engine write to a data byte or a buffer entry overrides a host write to that storage. An engine status set overrides a host clear of the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read data, valid while host_rd is high |
| start_pulse | output | 1 | One-cycle request to the command engine |
| ctrl_q | output | 8 | Stored control register |
| cmd_q | output | 8 | Stored command code |
| taddr_q | output | 8 | Stored target address |
| dat0_q | output | 8 | Data byte 0 |
| dat1_q | output | 8 | Data byte 1 |
| aux_q | output | 8 | Auxiliary control |
| eng_hsts_set | input | 8 | Engine set mask for host status |
| eng_ssts_set | input | 8 | Engine set mask for secondary status |
| eng_dat0_we | input | 1 | Engine write enable, data byte 0 |
| eng_dat0 | input | 8 | Engine data for data byte 0 |
| eng_dat1_we | input | 1 | Engine write enable, data byte 1 |
| eng_dat1 | input | 8 | Engine data for data byte 1 |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_widx | input | 5 | Engine buffer write index |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_ridx | input | 5 | Engine buffer read index |
| eng_buf_rdata | output | 8 | Buffer entry at eng_buf_ridx |

## Verification
A wrong offset does not show up at once. It becomes visible on the next block-port read, or through eng_buf_rdata, as a byte taken from or written to the neighbouring entry. It is caught within the first block access after the error. A lost start-bit strip shows directly on ctrl_q and on the next control read. A missing or doubled pulse shows on start_pulse one cycle after the control write edge. Status and data-byte errors appear on the next read of that address, so the random mix of reads against a reference model bounds detection to a few operations.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;

  localparam int ADDR_W         = 5;
  localparam int CTRL_START_BIT = 6;

  localparam logic [ADDR_W-1:0] A_HSTAT  = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h02;
  localparam logic [ADDR_W-1:0] A_CMD    = 5'h03;
  localparam logic [ADDR_W-1:0] A_TADDR  = 5'h04;
  localparam logic [ADDR_W-1:0] A_DAT0   = 5'h05;
  localparam logic [ADDR_W-1:0] A_DAT1   = 5'h06;
  localparam logic [ADDR_W-1:0] A_BLK    = 5'h07;
  localparam logic [ADDR_W-1:0] A_AUX    = 5'h0D;
  localparam logic [ADDR_W-1:0] A_SSTAT  = 5'h10;
  localparam logic [ADDR_W-1:0] A_NOTIFY = 5'h14;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_HSTAT,
    SEL_CTRL,
    SEL_CMD,
    SEL_TADDR,
    SEL_DAT0,
    SEL_DAT1,
    SEL_BLK,
    SEL_AUX,
    SEL_SSTAT,
    SEL_NOTIFY
  } reg_sel_e;

  // Next value of a write-one-to-clear byte with a priority set mask.
  function automatic logic [7:0] w1c_next(input logic [7:0] cur,
                                          input logic [7:0] clr,
                                          input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Control value as stored: the start bit is never kept.
  function automatic logic [7:0] ctrl_store(input logic [7:0] wr);
    logic [7:0] v;
    v = wr;
    v[CTRL_START_BIT] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/smb_addr_dec.sv
module smb_addr_dec
  import smb_regs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              mapped
);

  always_comb begin
    unique case (addr)
      A_HSTAT:  sel = SEL_HSTAT;
      A_CTRL:   sel = SEL_CTRL;
      A_CMD:    sel = SEL_CMD;
      A_TADDR:  sel = SEL_TADDR;
      A_DAT0:   sel = SEL_DAT0;
      A_DAT1:   sel = SEL_DAT1;
      A_BLK:    sel = SEL_BLK;
      A_AUX:    sel = SEL_AUX;
      A_SSTAT:  sel = SEL_SSTAT;
      A_NOTIFY: sel = SEL_NOTIFY;
      default:  sel = SEL_NONE;
    endcase
  end

  assign mapped = (sel != SEL_NONE);

endmodule

// File: rtl/smb_w1c_reg.sv
module smb_w1c_reg
  import smb_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_en,
  input  logic [7:0] clr_mask,
  input  logic [7:0] set_mask,
  output logic [7:0] q
);

  logic [7:0] eff_clr;
  assign eff_clr = clr_en ? clr_mask : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= w1c_next(q, eff_clr, set_mask);
  end

endmodule

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              off_clr,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              eng_we,
  input  logic [OFF_W-1:0]  eng_widx,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic [OFF_W-1:0]  eng_ridx,
  output logic [DATA_W-1:0] eng_rdata,
  output logic [OFF_W-1:0]  off_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [OFF_W-1:0] off_step(input logic [OFF_W-1:0] o);
    return (int'(o) == DEPTH-1) ? '0 : o + 1'b1;
  endfunction

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst)                                          mem[i] <= '0;
        else if (eng_we && (int'(eng_widx) == i))         mem[i] <= eng_wdata;
        else if (host_we && (int'(off_q) == i))           mem[i] <= host_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                       off_q <= '0;
    else if (off_clr)              off_q <= '0;
    else if (host_we || host_re)   off_q <= off_step(off_q);
  end

  assign host_rdata = mem[off_q];
  assign eng_rdata  = mem[eng_ridx];

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_regs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 32,
  localparam int OFF_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              start_pulse,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] taddr_q,
  output logic [DATA_W-1:0] dat0_q,
  output logic [DATA_W-1:0] dat1_q,
  output logic [DATA_W-1:0] aux_q,
  input  logic [DATA_W-1:0] eng_hsts_set,
  input  logic [DATA_W-1:0] eng_ssts_set,
  input  logic              eng_dat0_we,
  input  logic [DATA_W-1:0] eng_dat0,
  input  logic              eng_dat1_we,
  input  logic [DATA_W-1:0] eng_dat1,
  input  logic              eng_buf_we,
  input  logic [OFF_W-1:0]  eng_buf_widx,
  input  logic [DATA_W-1:0] eng_buf_wdata,
  input  logic [OFF_W-1:0]  eng_buf_ridx,
  output logic [DATA_W-1:0] eng_buf_rdata
);

  reg_sel_e          sel;
  logic              mapped;
  logic              wr_ev, rd_ev;
  logic              hsts_clr, ssts_clr;
  logic              ctrl_rd_evt, blk_wr, blk_rd, blk_step;
  logic              start_req, unmapped_rd;
  logic [DATA_W-1:0] hsts_q, ssts_q, notify_q, blk_rdata;
  logic [OFF_W-1:0]  blk_off;

  smb_addr_dec u_dec (
    .addr   (host_addr),
    .sel    (sel),
    .mapped (mapped)
  );

  // Named host events; a write wins over a read in the same cycle.
  assign wr_ev       = host_wr;
  assign rd_ev       = host_rd && !host_wr;
  assign hsts_clr    = wr_ev && (sel == SEL_HSTAT);
  assign ssts_clr    = wr_ev && (sel == SEL_SSTAT);
  assign ctrl_rd_evt = rd_ev && (sel == SEL_CTRL);
  assign blk_wr      = wr_ev && (sel == SEL_BLK);
  assign blk_rd      = rd_ev && (sel == SEL_BLK);
  assign blk_step    = blk_wr || blk_rd;
  assign start_req   = wr_ev && (sel == SEL_CTRL) && host_wdata[CTRL_START_BIT];
  assign unmapped_rd = rd_ev && !mapped;

  smb_w1c_reg u_hsts (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (hsts_clr),
    .clr_mask (host_wdata),
    .set_mask (eng_hsts_set),
    .q        (hsts_q)
  );

  smb_w1c_reg u_ssts (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (ssts_clr),
    .clr_mask (host_wdata),
    .set_mask (eng_ssts_set),
    .q        (ssts_q)
  );

  smb_blk_buf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .off_clr    (ctrl_rd_evt),
    .host_we    (blk_wr),
    .host_re    (blk_rd),
    .host_wdata (host_wdata),
    .host_rdata (blk_rdata),
    .eng_we     (eng_buf_we),
    .eng_widx   (eng_buf_widx),
    .eng_wdata  (eng_buf_wdata),
    .eng_ridx   (eng_buf_ridx),
    .eng_rdata  (eng_buf_rdata),
    .off_q      (blk_off)
  );

  // Plain storage registers; engine writes take priority.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      cmd_q       <= '0;
      taddr_q     <= '0;
      dat0_q      <= '0;
      dat1_q      <= '0;
      aux_q       <= '0;
      notify_q    <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= start_req;
      if (wr_ev && sel == SEL_CTRL)   ctrl_q   <= ctrl_store(host_wdata);
      if (wr_ev && sel == SEL_CMD)    cmd_q    <= host_wdata;
      if (wr_ev && sel == SEL_TADDR)  taddr_q  <= host_wdata;
      if (wr_ev && sel == SEL_AUX)    aux_q    <= host_wdata;
      if (wr_ev && sel == SEL_NOTIFY) notify_q <= host_wdata;
      if (eng_dat0_we)                   dat0_q <= eng_dat0;
      else if (wr_ev && sel == SEL_DAT0) dat0_q <= host_wdata;
      if (eng_dat1_we)                   dat1_q <= eng_dat1;
      else if (wr_ev && sel == SEL_DAT1) dat1_q <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (rd_ev) begin
      unique case (sel)
        SEL_HSTAT:  host_rdata = hsts_q;
        SEL_CTRL:   host_rdata = ctrl_q;
        SEL_CMD:    host_rdata = cmd_q;
        SEL_TADDR:  host_rdata = taddr_q;
        SEL_DAT0:   host_rdata = dat0_q;
        SEL_DAT1:   host_rdata = dat1_q;
        SEL_BLK:    host_rdata = blk_rdata;
        SEL_AUX:    host_rdata = aux_q;
        SEL_SSTAT:  host_rdata = ssts_q;
        SEL_NOTIFY: host_rdata = notify_q;
        default:    host_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 32,
  parameter int OFF_W     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              hsts_clr,
  input logic              ctrl_rd_evt,
  input logic              blk_step,
  input logic              start_req,
  input logic              start_pulse,
  input logic              unmapped_rd,
  input logic [OFF_W-1:0]  blk_off,
  input logic [DATA_W-1:0] hsts_q,
  input logic [DATA_W-1:0] eng_hsts_set,
  input logic              eng_dat0_we,
  input logic [DATA_W-1:0] eng_dat0,
  input logic [DATA_W-1:0] dat0_q,
  input logic [DATA_W-1:0] ctrl_q
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_W1C_HSTAT: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(hsts_clr) && ($past(eng_hsts_set) == '0)
      |-> hsts_q == ($past(hsts_q) & ~$past(host_wdata))); // R2

  AST_OFF_STEP: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(blk_step) && !$past(ctrl_rd_evt)
      |-> int'(blk_off) == ((int'($past(blk_off)) + 1) % BUF_DEPTH)); // R10

  AST_OFF_CLR: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(ctrl_rd_evt) |-> blk_off == '0); // R6

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
    past_ok && start_pulse |-> $past(start_req)); // R7

  AST_START_NOT_KEPT: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[6]); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    unmapped_rd |-> host_rdata == '0); // R9

  AST_ENG_DAT0_WINS: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(eng_dat0_we) |-> dat0_q == $past(eng_dat0)); // R11

  AST_ENG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (hsts_q & $past(eng_hsts_set)) == $past(eng_hsts_set)); // R11

endmodule

bind smb_host_regs smb_host_regs_chk #(
  .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .OFF_W(OFF_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_wdata   (host_wdata),
  .host_rdata   (host_rdata),
  .hsts_clr     (hsts_clr),
  .ctrl_rd_evt  (ctrl_rd_evt),
  .blk_step     (blk_step),
  .start_req    (start_req),
  .start_pulse  (start_pulse),
  .unmapped_rd  (unmapped_rd),
  .blk_off      (blk_off),
  .hsts_q       (hsts_q),
  .eng_hsts_set (eng_hsts_set),
  .eng_dat0_we  (eng_dat0_we),
  .eng_dat0     (eng_dat0),
  .dat0_q       (dat0_q),
  .ctrl_q       (ctrl_q)
);

// File: tb/smb_host_regs_tb.sv
module smb_host_regs_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       start_pulse;
  logic [7:0] ctrl_q, cmd_q, taddr_q, dat0_q, dat1_q, aux_q;
  logic [7:0] eng_hsts_set = '0, eng_ssts_set = '0;
  logic       eng_dat0_we = 1'b0, eng_dat1_we = 1'b0, eng_buf_we = 1'b0;
  logic [7:0] eng_dat0 = '0, eng_dat1 = '0, eng_buf_wdata = '0;
  logic [4:0] eng_buf_widx = '0, eng_buf_ridx = '0;
  logic [7:0] eng_buf_rdata;

  always #2.5 clk = ~clk;

  smb_host_regs u_dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_reg [32];
  logic [7:0] m_buf [32];
  int m_off = 0;

  function automatic bit is_mapped(input int a);
    return a == 0 || a == 2 || a == 3 || a == 4 || a == 5 || a == 6 ||
           a == 7 || a == 13 || a == 16 || a == 20;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [7:0] d, input string tag);
    @(negedge clk);
    host_addr = 5'(a); host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    if (a == 0 || a == 16)      m_reg[a] = m_reg[a] & ~d;
    else if (a == 2)            m_reg[a] = d & 8'hBF;
    else if (a == 7) begin      m_buf[m_off] = d; m_off = (m_off + 1) % 32; end
    else if (is_mapped(a))      m_reg[a] = d;
    if (a == 2) chk({tag, " R7 pulse"}, {7'd0, start_pulse}, {7'd0, d[6]});
  endtask

  task automatic host_read(input int a, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    host_addr = 5'(a); host_rd = 1'b1;
    #1;
    if (a == 7) begin exp = m_buf[m_off]; m_off = (m_off + 1) % 32; end
    else if (is_mapped(a)) exp = m_reg[a];
    else exp = 8'h00;
    if (a == 2) m_off = 0;
    chk(tag, host_rdata, exp);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1DC5));
    for (int i = 0; i < 32; i++) begin m_reg[i] = '0; m_buf[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 start_pulse", {7'd0, start_pulse}, 8'h00);
    chk("R1 ctrl_q", ctrl_q, 8'h00);
    chk("R1 dat0_q", dat0_q, 8'h00);
    for (int a = 0; a < 24; a++) if (is_mapped(a) && a != 7) host_read(a, "R1 reg");
    eng_buf_ridx = 5'd31; #1; chk("R1 buf", eng_buf_rdata, 8'h00);

    // R8: plain registers
    host_write(3, 8'h5A, "R8"); host_write(4, 8'hA6, "R8");
    host_write(5, 8'h11, "R8"); host_write(6, 8'hFE, "R8");
    host_write(13, 8'h02, "R8"); host_write(20, 8'h6C, "R8");
    chk("R8 cmd_q", cmd_q, 8'h5A); chk("R8 aux_q", aux_q, 8'h02);
    host_read(3, "R8 cmd"); host_read(4, "R8 taddr"); host_read(13, "R8 aux");
    host_read(20, "R8 notify"); host_read(6, "R8 dat1");

    // R2/R3: write-one-to-clear
    @(negedge clk); eng_hsts_set = 8'hF3; eng_ssts_set = 8'h3C;
    @(negedge clk); eng_hsts_set = 8'h00; eng_ssts_set = 8'h00;
    m_reg[0] = 8'hF3; m_reg[16] = 8'h3C;
    host_write(0, 8'h41, "R2"); host_read(0, "R2 hstat");
    host_write(16, 8'h0C, "R3"); host_read(16, "R3 sstat");

    // R7: start bit
    host_write(2, 8'h4D, "R7");
    chk("R7 stored", ctrl_q, 8'h0D);
    @(negedge clk); chk("R7 pulse width", {7'd0, start_pulse}, 8'h00);
    host_write(2, 8'h09, "R7 nostart");

    // R4/R5/R6: block port
    host_read(2, "R6 ctrl");
    host_write(7, 8'hA1, "R4"); host_write(7, 8'hB2, "R4"); host_write(7, 8'hC3, "R4");
    eng_buf_ridx = 5'd1; #1; chk("R4 entry1", eng_buf_rdata, 8'hB2);
    host_read(2, "R6 ctrl clears offset");
    host_read(7, "R5 read0"); host_read(7, "R5 read1"); host_read(7, "R5 read2");

    // R10: wrap
    host_read(2, "R6 ctrl");
    for (int i = 0; i < 33; i++) host_write(7, 8'(i + 8'h40), "R10");
    eng_buf_ridx = 5'd0; #1; chk("R10 wrap entry0", eng_buf_rdata, 8'h60);
    eng_buf_ridx = 5'd31; #1; chk("R10 entry31", eng_buf_rdata, 8'h5F);
    host_read(7, "R10 offset after wrap");

    // R9: unmapped
    host_write(1, 8'hFF, "R9"); host_write(23, 8'hFF, "R9");
    host_read(1, "R9 rd1"); host_read(23, "R9 rd23"); host_read(9, "R9 rd9");
    host_read(3, "R9 cmd untouched");

    // R11: engine priority
    @(negedge clk);
    host_addr = 5'd5; host_wdata = 8'h33; host_wr = 1'b1;
    eng_dat0_we = 1'b1; eng_dat0 = 8'h77;
    @(negedge clk);
    host_wr = 1'b0; eng_dat0_we = 1'b0; m_reg[5] = 8'h77;
    chk("R11 dat0", dat0_q, 8'h77);
    @(negedge clk);
    host_addr = 5'd0; host_wdata = 8'hFF; host_wr = 1'b1; eng_hsts_set = 8'h01;
    @(negedge clk);
    host_wr = 1'b0; eng_hsts_set = 8'h00; m_reg[0] = 8'h01;
    host_read(0, "R11 hstat set wins");
    @(negedge clk);
    host_addr = 5'd7; host_wdata = 8'h99; host_wr = 1'b1;
    eng_buf_we = 1'b1; eng_buf_widx = 5'(m_off); eng_buf_wdata = 8'hEE;
    @(negedge clk);
    host_wr = 1'b0; eng_buf_we = 1'b0;
    eng_buf_ridx = 5'(m_off); m_buf[m_off] = 8'hEE; m_off = (m_off + 1) % 32;
    #1; chk("R11 buf", eng_buf_rdata, 8'hEE);

    // Random mix against the model
    for (int i = 0; i < 400; i++) begin
      int a;
      a = int'($urandom_range(0, 23));
      if ($urandom_range(0, 1) == 0) host_write(a, 8'($urandom), "RND R4 R8 R2");
      else                           host_read(a, "RND R5 R6 R9");
    end

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule